// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the sequence of column addresses for one read or write burst of a synchronous DRAM whose page holds 256 columns. When a start strobe is sampled, the block captures the starting column, a 3-bit burst-length code and an order select (sequential or interleave). From the next cycle it drives one column address per clock, with a valid flag and a flag that marks the final address of a fixed-length burst.

A full-page burst steps through the whole page and wraps. It runs until a stop strobe ends it or a new start replaces it. A stop ends any burst early. A start may arrive on any cycle, and it replaces a running burst at once. Interleave order combined with full-page length is not a legal setting. The block raises a configuration error flag for such a burst and runs it as an 8-word interleave burst. The block sits between the command decoder and the column path of a memory controller or memory model.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset (active low) is held, and afterwards until the first start, `valid`, `last` and `cfg_err` are 0 and `col` reads 0.
- R2: When `start` is sampled high on a rising edge, `valid` is 1 and `col` equals the sampled `start_col` in the following cycle.
- R3: Burst-length code: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, and any code with bit 2 set selects full page. A fixed-length burst that is not stopped or replaced shows exactly that many addresses on consecutive cycles, and then `valid` falls.
- R4: With `order_ilv`=0 and a fixed length BL, address i of the burst is (start + i) mod BL in the low log2(BL) bits, and the upper column bits keep their starting value.
- R5: With `order_ilv`=1, address i has start XOR i in the low log2(BL) bits, and the upper bits keep their starting value.
- R6: A sequential full-page burst increments the column by one each cycle, wrapping from 255 to 0. It continues until a stop or a start is sampled.
- R7: `last` is 1 exactly in the cycle that shows address BL-1 of a fixed-length burst. It is never 1 during a full-page burst or while `valid` is 0.
- R8: `stop` sampled high without `start` makes `valid` 0 from the next cycle. When no burst is running, `stop` has no effect.
- R9: `start` sampled during a running burst replaces that burst from the next cycle. If `start` and `stop` are sampled on the same edge, `start` wins.
- R10: Interleave order with a full-page code sets `cfg_err` for every cycle of that burst, and the burst runs as an 8-word interleave burst. For legal settings `cfg_err` is 0.
- R11: `start_col`, `blen_code` and `order_ilv` are ignored on every edge where `start` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new burst using the inputs sampled on the same edge |
| stop | input | 1 | End the running burst |
| start_col | input | 8 | Starting column address |
| blen_code | input | 3 | Burst-length code (see R3) |
| order_ilv | input | 1 | 0 = sequential order, 1 = interleave order |
| col | output | 8 | Current column address, 0 while idle |
| valid | output | 1 | `col` holds a burst address |
| last | output | 1 | Final address of a fixed-length burst |
| cfg_err | output | 1 | Current burst uses the illegal interleave/full-page setting |

## Verification
The assertions check, on every cycle, the timing rules around the flags. They cover the load of the start column one cycle after a start, the fall of `valid` after a stop or after `last`, the step by one of a full-page burst, the flags being qualified by `valid`, and the captured start column being held. The exact address orders are shown only by the bench's scenarios. These include sequential wrap inside aligned blocks of 2, 4 and 8 words, XOR order from unaligned starts, wrap past column 255 in a 300-cycle page burst, and the error burst's fallback to 8-word interleave. Replacement mid-burst, start and stop on the same edge, stop while idle, and input changes on cycles without a start are also covered only by those scenarios.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

   // address ordering inside a burst
   typedef enum logic {
      ORDER_SEQ = 1'b0,
      ORDER_ILV = 1'b1
   } burst_order_e;

   // log2 of the longest fixed-length burst
   localparam int unsigned MAX_FIXED_LG = 3;

endpackage

// File: rtl/sdram_blen_decode.sv
module sdram_blen_decode #(
   parameter int unsigned COL_W = 8
) (
   input  logic [2:0]       code,
   input  logic             ilv,
   output logic [COL_W-1:0] mask,
   output logic             full,
   output logic             err
);
   import sdram_col_pkg::*;

   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic [1:0] lg;

   generate
      if (COL_W <= MAX_FIXED_LG) begin : g_width_bad
         $error("sdram_blen_decode: COL_W must exceed the longest fixed burst");
      end
   endgenerate

   always_comb begin
      full = code[2] & ~ilv;
      err  = code[2] &  ilv;
      lg   = code[2] ? 2'(MAX_FIXED_LG) : code[1:0];
      if (full)
         mask = {COL_W{1'b1}};
      else
         mask = (ONE << lg) - ONE;
   end

endmodule

// File: rtl/sdram_col_counter.sv
module sdram_col_counter #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] start_col,
   input  logic [COL_W-1:0] mask_in,
   input  logic             full_in,
   input  logic             err_in,
   input  logic             ilv_in,
   output logic             valid,
   output logic [COL_W-1:0] base,
   output logic [COL_W-1:0] cnt,
   output logic [COL_W-1:0] mask,
   output logic             full,
   output logic             err,
   output logic             ilv,
   output logic             last
);

   assign last = valid & ~full & (cnt == mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         base  <= '0;
         cnt   <= '0;
         mask  <= '0;
         full  <= 1'b0;
         err   <= 1'b0;
         ilv   <= 1'b0;
      end else if (start) begin
         valid <= 1'b1;
         base  <= start_col;
         cnt   <= '0;
         mask  <= mask_in;
         full  <= full_in;
         err   <= err_in;
         ilv   <= ilv_in;
      end else if (stop) begin
         valid <= 1'b0;
      end else if (valid) begin
         if (last)
            valid <= 1'b0;
         else
            cnt <= cnt + 1'b1;
      end
   end

   // R8
   stop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !valid);

   // R3
   burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !start) |=> !valid);

   // R11
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !start) |=> $stable(base));

endmodule

// File: rtl/sdram_col_map.sv
module sdram_col_map #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] cnt,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] addr
);
   import sdram_col_pkg::*;

   logic [COL_W-1:0] seq_addr;
   logic [COL_W-1:0] ilv_addr;

   generate
      for (genvar b = 0; b < COL_W; b++) begin : g_bit
         assign seq_addr[b] = mask[b] ? (base[b:0] + cnt[b:0]) >> b : base[b];
         assign ilv_addr[b] = mask[b] ? (base[b] ^ cnt[b]) : base[b];
      end
   endgenerate

   assign addr = (burst_order_e'(ilv) == ORDER_ILV) ? ilv_addr : seq_addr;

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       blen_code,
   input  logic             order_ilv,
   output logic [COL_W-1:0] col,
   output logic             valid,
   output logic             last,
   output logic             cfg_err
);

   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic             dec_err;
   logic [COL_W-1:0] r_base;
   logic [COL_W-1:0] r_cnt;
   logic [COL_W-1:0] r_mask;
   logic             r_full;
   logic             r_err;
   logic             r_ilv;
   logic             r_valid;
   logic             r_last;
   logic [COL_W-1:0] map_addr;

   sdram_blen_decode #(.COL_W(COL_W)) u_dec (
      .code (blen_code),
      .ilv  (order_ilv),
      .mask (dec_mask),
      .full (dec_full),
      .err  (dec_err)
   );

   sdram_col_counter #(.COL_W(COL_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .start_col (start_col),
      .mask_in   (dec_mask),
      .full_in   (dec_full),
      .err_in    (dec_err),
      .ilv_in    (order_ilv),
      .valid     (r_valid),
      .base      (r_base),
      .cnt       (r_cnt),
      .mask      (r_mask),
      .full      (r_full),
      .err       (r_err),
      .ilv       (r_ilv),
      .last      (r_last)
   );

   sdram_col_map #(.COL_W(COL_W)) u_map (
      .base (r_base),
      .cnt  (r_cnt),
      .mask (r_mask),
      .ilv  (r_ilv),
      .addr (map_addr)
   );

   assign valid   = r_valid;
   assign last    = r_last;
   assign cfg_err = r_valid & r_err;
   assign col     = r_valid ? map_addr : '0;

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (valid && col == $past(start_col)));

   // R6
   page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && r_full && !start && !stop) |=> (valid && col == COL_W'($past(col) + 1'b1)));

   // R7
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> (valid && !r_full));

   // R10
   err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (valid && !last || valid));

   // R1
   idle_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (col == '0 && !last && !cfg_err));

endmodule

// File: tb/sdram_col_seq_test.sv
`timescale 1ns/1ps
module sdram_col_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       stop = 1'b0;
   logic [7:0] start_col = '0;
   logic [2:0] blen_code = '0;
   logic       order_ilv = 1'b0;
   logic [7:0] col;
   logic       valid;
   logic       last;
   logic       cfg_err;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [7:0] col;
      bit         last;
      bit         err;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #2.5 clk = ~clk;

   sdram_col_seq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .start_col (start_col),
      .blen_code (blen_code),
      .order_ilv (order_ilv),
      .col       (col),
      .valid     (valid),
      .last      (last),
      .cfg_err   (cfg_err)
   );

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // expected address i of a burst, computed from the requirements
   function automatic exp_t model(logic [7:0] sc, logic [2:0] code, bit il, int i, string tag);
      exp_t e;
      int   bl;
      bit   full;
      int   m;
      full = code[2] && !il;
      if (code[2]) bl = full ? 256 : 8;
      else bl = 1 << code[1:0];
      m = bl - 1;
      if (il) e.col = 8'((sc & ~m) | ((sc ^ i) & m));
      else    e.col = 8'((sc & ~m) | ((sc + i) & m));
      e.last = !full && (i == bl - 1);
      e.err  = code[2] && il;
      e.tag  = tag;
      return e;
   endfunction

   // drive a start at the current negedge; n addresses are expected before
   // the caller acts again; after return we sit at the negedge before edge k+n
   task automatic kick(logic [7:0] sc, logic [2:0] code, bit il, int n, bit stop_too, string tag);
      start     = 1'b1;
      stop      = stop_too;
      start_col = sc;
      blen_code = code;
      order_ilv = il;
      for (int i = 0; i < n; i++) q.push_back(model(sc, code, il, i, tag));
      @(negedge clk);
      start     = 1'b0;
      stop      = 1'b0;
      // R11: scramble the ignored inputs while the burst runs
      start_col = ~sc;
      blen_code = code ^ 3'd5;
      order_ilv = ~il;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic pulse_stop();
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   task automatic settle(string tag);
      repeat (3) @(negedge clk);
      check(q.size() == 0, tag, q.size(), 0);
      check(valid == 1'b0, tag, valid, 0);
   endtask

   // monitor: scoreboard compare just after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n && valid) begin
         if (q.size() == 0) begin
            check(1'b0, "R3/R8 unexpected address", col, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(col == e.col, e.tag, col, e.col);
            check(last == e.last, {e.tag, " last"}, last, e.last);
            check(cfg_err == e.err, {e.tag, " R10 cfg_err"}, cfg_err, e.err);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state under reset
      check(valid == 0 && last == 0 && cfg_err == 0 && col == 0, "R1 in reset",
            {col, valid, last, cfg_err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(valid == 0 && last == 0 && cfg_err == 0 && col == 0, "R1 after reset",
            {col, valid, last, cfg_err}, 0);

      // R8: stop while idle has no effect
      pulse_stop();
      @(negedge clk);
      check(valid == 1'b0, "R8 idle stop", valid, 0);

      // R2 R3 sequential lengths
      kick(8'h35, 3'd0, 1'b0, 1, 1'b0, "R2 R3 bl1");
      settle("R3 bl1 end");
      kick(8'h35, 3'd1, 1'b0, 2, 1'b0, "R4 bl2 seq");
      settle("R3 bl2 end");
      kick(8'h36, 3'd2, 1'b0, 4, 1'b0, "R4 bl4 seq");
      settle("R3 bl4 end");
      kick(8'h3D, 3'd3, 1'b0, 8, 1'b0, "R4 bl8 seq");
      settle("R3 bl8 end");

      // R5 interleave
      kick(8'h35, 3'd2, 1'b1, 4, 1'b0, "R5 bl4 ilv");
      settle("R5 bl4 end");
      kick(8'h3D, 3'd3, 1'b1, 8, 1'b0, "R5 bl8 ilv");
      settle("R5 bl8 end");
      kick(8'hA6, 3'd1, 1'b1, 2, 1'b0, "R5 bl2 ilv");
      settle("R5 bl2 end");

      // R6 full page with wrap past 255, then stop
      kick(8'hFA, 3'd7, 1'b0, 300, 1'b0, "R6 R7 full page");
      pulse_stop();
      settle("R6 R8 page stop");

      // R10 illegal setting runs as 8-word interleave
      kick(8'h13, 3'd4, 1'b1, 8, 1'b0, "R10 ilv full");
      settle("R10 end");

      // R8 stop mid burst
      kick(8'h40, 3'd3, 1'b0, 3, 1'b0, "R8 pre stop");
      pulse_stop();
      settle("R8 mid stop");

      // R9 interrupt by a new start
      kick(8'h10, 3'd3, 1'b0, 5, 1'b0, "R9 first");
      kick(8'h22, 3'd2, 1'b0, 4, 1'b0, "R9 second");
      settle("R9 end");

      // R9 start and stop on the same edge: start wins
      kick(8'h48, 3'd3, 1'b0, 2, 1'b0, "R9 pre");
      kick(8'h51, 3'd1, 1'b0, 2, 1'b1, "R9 start over stop");
      settle("R9 tie end");

      // R9 interrupt of a full-page burst
      kick(8'hFE, 3'd5, 1'b0, 4, 1'b0, "R9 page");
      kick(8'h07, 3'd0, 1'b1, 1, 1'b0, "R9 after page");
      settle("R9 page end");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule